// File: doc/BRIEF.md
# Width-Aware Atomic Read-Modify-Write Datapath

This block computes the two data results of one atomic read-modify-write memory operation: the value to be written back to memory and the value returned to the destination register. The caller presents a 5-bit operation code, a 2-bit access size, the raw second source register and the raw value read from memory. The operation may be a swap, an add, a bitwise xor, and, or, or a signed or unsigned minimum or maximum.

Both operands are first narrowed to the access size and widened back to 64 bits. The unsigned minimum and maximum zero-extend them. All other operations sign-extend them. The result is then cut to the access size for the store. The register return value is always the loaded value's low bytes, sign-extended, whatever the operation. Memory sequencing, address handling and faults belong to the surrounding pipeline.

The datapath is combinational behind one output register stage. A request presented with `in_valid` high yields its results on the next rising clock edge.

Top module: `amo_alu`

## Requirements
- R1: While `rst_n` is low, `out_valid`, `illegal_op`, `store_data` and `rd_value` are all zero.
- R2: Operation codes are 00001 swap, 00000 add, 00100 xor, 01100 and, 01000 or, 10000 min, 10100 max, 11000 min-unsigned and 11100 max-unsigned. Only 11000 and 11100 treat their operands as unsigned. Below 8 bytes, both operands are reduced to their low 1 << `size` bytes. The unsigned codes then zero-extend them and all other codes sign-extend them. Size code 3 (8 bytes) uses both operands unchanged.
- R3: Swap yields the extended rs2 operand as its result.
- R4: Add yields the sum of the two extended operands modulo 2^64, with no overflow indication.
- R5: Xor, and and or yield the bitwise combination of the two extended operands.
- R6: Min and max compare the extended operands as signed two's-complement integers and yield the smaller or the larger one.
- R7: Min-unsigned and max-unsigned compare the extended operands as unsigned integers and yield the smaller or the larger one.
- R8: `store_data` holds the low 1 << `size` bytes of the result (size 0=1, 1=2, 2=4, 3=8 bytes), and all bits above them are zero.
- R9: `rd_value` is the low 1 << `size` bytes of `mem_raw`, sign-extended to 64 bits, for every legal operation including the unsigned ones.
- R10: Any other operation code sets `illegal_op`, and `store_data` and `rd_value` are then zero.
- R11: `out_valid` is `in_valid` delayed by one clock. In a cycle after `in_valid` was low, all result outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| funct5 | input | 5 | Operation code |
| size | input | 2 | Access size code, bytes = 1 << size |
| rs2_raw | input | 64 | Raw second source register value |
| mem_raw | input | 64 | Raw value loaded from memory |
| out_valid | output | 1 | Results of the previous cycle's request are present |
| store_data | output | 64 | Value to store, zero above the access size |
| rd_value | output | 64 | Sign-extended value for the destination register |
| illegal_op | output | 1 | Previous request carried an unknown operation code |

## Verification
Every result of this block is due exactly one rising edge after the request: store data, register return value, illegal flag and valid all come out of the same register stage. The bench drives a request just after a falling edge. At the next falling edge it compares all four outputs against values its model computed when it drove that request. Between accepted requests it also checks that the outputs hold still. The assertions state the same one-edge relation with single-cycle implications.

// File: rtl/amo_alu_pkg.sv
package amo_alu_pkg;

  localparam int XLEN      = 64;
  localparam int SIZE_W    = 2;
  localparam int OPC_W     = 5;
  localparam int NUM_SIZES = 1 << SIZE_W;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD  = 5'b00000,
    OPC_SWAP = 5'b00001,
    OPC_XOR  = 5'b00100,
    OPC_OR   = 5'b01000,
    OPC_AND  = 5'b01100,
    OPC_MIN  = 5'b10000,
    OPC_MAX  = 5'b10100,
    OPC_MINU = 5'b11000,
    OPC_MAXU = 5'b11100
  } amo_opc_e;

  // Width-limited extension of a lane of LANE_BITS bits to XLEN.
  function automatic logic [XLEN-1:0] lane_extend(
    input logic [XLEN-1:0] v,
    input int unsigned     lane_bits,
    input logic            sgn
  );
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) begin
      if (i < lane_bits) r[i] = v[i];
      else               r[i] = sgn & v[lane_bits-1];
    end
    return r;
  endfunction

  function automatic logic opc_known(input logic [OPC_W-1:0] c);
    return c inside {OPC_ADD, OPC_SWAP, OPC_XOR, OPC_OR, OPC_AND,
                     OPC_MIN, OPC_MAX, OPC_MINU, OPC_MAXU};
  endfunction

  function automatic logic opc_unsigned(input logic [OPC_W-1:0] c);
    return (c == OPC_MINU) || (c == OPC_MAXU);
  endfunction

endpackage

// File: rtl/amo_size_ext.sv
module amo_size_ext
  import amo_alu_pkg::*;
(
  input  logic [XLEN-1:0]   raw,
  input  logic [SIZE_W-1:0] size,
  input  logic              sgn,
  output logic [XLEN-1:0]   ext
);
  logic [XLEN-1:0] lane_val [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
    localparam int unsigned LANE_BITS = 8 << g;
    if (LANE_BITS >= XLEN) begin : g_full
      assign lane_val[g] = raw;
    end else begin : g_part
      assign lane_val[g] = lane_extend(raw, LANE_BITS, sgn);
    end
  end

  assign ext = lane_val[size];
endmodule

// File: rtl/amo_op_unit.sv
module amo_op_unit
  import amo_alu_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  input  logic [XLEN-1:0]  opnd_src,
  input  logic [XLEN-1:0]  opnd_mem,
  output logic [XLEN-1:0]  result,
  output logic             src_lt_s,
  output logic             src_lt_u
);
  assign src_lt_s = $signed(opnd_src) < $signed(opnd_mem);
  assign src_lt_u = opnd_src < opnd_mem;

  always_comb begin
    case (opc)
      OPC_SWAP: result = opnd_src;
      OPC_ADD:  result = opnd_src + opnd_mem;
      OPC_XOR:  result = opnd_src ^ opnd_mem;
      OPC_AND:  result = opnd_src & opnd_mem;
      OPC_OR:   result = opnd_src | opnd_mem;
      OPC_MIN:  result = src_lt_s ? opnd_src : opnd_mem;
      OPC_MAX:  result = src_lt_s ? opnd_mem : opnd_src;
      OPC_MINU: result = src_lt_u ? opnd_src : opnd_mem;
      OPC_MAXU: result = src_lt_u ? opnd_mem : opnd_src;
      default:  result = '0;
    endcase
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  funct5,
  input  logic [SIZE_W-1:0] size,
  input  logic [XLEN-1:0]   rs2_raw,
  input  logic [XLEN-1:0]   mem_raw,
  output logic              out_valid,
  output logic [XLEN-1:0]   store_data,
  output logic [XLEN-1:0]   rd_value,
  output logic              illegal_op
);
  logic            op_legal;
  logic            op_signed;
  logic [XLEN-1:0] src_ext;
  logic [XLEN-1:0] mem_ext;
  logic [XLEN-1:0] rd_ext;
  logic [XLEN-1:0] op_result;
  logic [XLEN-1:0] store_trim;
  logic            cmp_lt_s;
  logic            cmp_lt_u;

  assign op_legal  = opc_known(funct5);
  assign op_signed = ~opc_unsigned(funct5);

  amo_size_ext u_src_ext (.raw(rs2_raw), .size(size), .sgn(op_signed), .ext(src_ext));
  amo_size_ext u_mem_ext (.raw(mem_raw), .size(size), .sgn(op_signed), .ext(mem_ext));
  amo_size_ext u_rd_ext  (.raw(mem_raw), .size(size), .sgn(1'b1),      .ext(rd_ext));

  amo_op_unit u_op (
    .opc      (funct5),
    .opnd_src (src_ext),
    .opnd_mem (mem_ext),
    .result   (op_result),
    .src_lt_s (cmp_lt_s),
    .src_lt_u (cmp_lt_u)
  );

  amo_size_ext u_store_trim (.raw(op_result), .size(size), .sgn(1'b0), .ext(store_trim));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      store_data <= '0;
      rd_value   <= '0;
      illegal_op <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        illegal_op <= ~op_legal;
        store_data <= op_legal ? store_trim : '0;
        rd_value   <= op_legal ? rd_ext : '0;
      end
    end
  end
endmodule

// File: rtl/amo_alu_chk.sv
module amo_alu_chk
  import amo_alu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [OPC_W-1:0]  funct5,
  input logic [SIZE_W-1:0] size,
  input logic [XLEN-1:0]   rs2_raw,
  input logic [XLEN-1:0]   mem_raw,
  input logic              out_valid,
  input logic [XLEN-1:0]   store_data,
  input logic [XLEN-1:0]   rd_value,
  input logic              illegal_op
);
  p_valid_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_idle_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(store_data) && $stable(rd_value) && $stable(illegal_op)));
  p_illegal_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> (store_data == '0 && rd_value == '0));
  p_byte_store_trim_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'd0) |=> (store_data[XLEN-1:8] == '0));
  p_byte_rd_sext_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'd0) |=> (illegal_op || rd_value[XLEN-1:8] == {(XLEN-8){rd_value[7]}}));
  p_dword_rd_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'd3) |=> (illegal_op || rd_value == $past(mem_raw)));
  p_dword_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'd3 && funct5 == OPC_SWAP) |=> (store_data == $past(rs2_raw)));
endmodule

bind amo_alu amo_alu_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .funct5(funct5), .size(size),
  .rs2_raw(rs2_raw), .mem_raw(mem_raw), .out_valid(out_valid),
  .store_data(store_data), .rd_value(rd_value), .illegal_op(illegal_op)
);

// File: tb/amo_alu_test.sv
module amo_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  funct5 = '0;
  logic [1:0]  size = '0;
  logic [63:0] rs2_raw = '0;
  logic [63:0] mem_raw = '0;
  logic        out_valid;
  logic [63:0] store_data;
  logic [63:0] rd_value;
  logic        illegal_op;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit          m_valid = 1'b0;
  bit          m_ill = 1'b0;
  logic [63:0] m_store = '0;
  logic [63:0] m_rd = '0;
  string       m_tag = "R1";

  always #5 clk = ~clk;

  amo_alu uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .funct5(funct5), .size(size),
    .rs2_raw(rs2_raw), .mem_raw(mem_raw), .out_valid(out_valid),
    .store_data(store_data), .rd_value(rd_value), .illegal_op(illegal_op)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_ext(input logic [63:0] v, input int sz, input bit sgn);
    int sh = 64 - (8 << sz);
    longint s;
    if (sh == 0) return v;
    if (sgn) begin
      s = longint'(v << sh);
      s = s >>> sh;
      return 64'(s);
    end
    return (v << sh) >> sh;
  endfunction

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      5'd1: return "R3";
      5'd0: return "R4";
      5'd4, 5'd8, 5'd12: return "R5";
      5'd16, 5'd20: return "R6";
      5'd24, 5'd28: return "R7";
      default: return "R10";
    endcase
  endfunction

  // Compare the outputs due now, then present the next request and update the model.
  task automatic step(input bit v, input logic [4:0] op, input int sz,
                      input logic [63:0] a, input logic [63:0] b, input string tag);
    bit uns, legal;
    longint unsigned x, y, r;
    @(negedge clk);
    check(out_valid == m_valid, "R11", "out_valid", 64'(out_valid), 64'(m_valid));
    check(illegal_op == m_ill, (m_ill ? "R10" : m_tag), "illegal_op", 64'(illegal_op), 64'(m_ill));
    check(store_data == m_store, (m_valid ? m_tag : "R11"), "store_data", store_data, m_store);
    check(rd_value == m_rd, (m_valid ? "R9" : "R11"), "rd_value", rd_value, m_rd);
    in_valid = v; funct5 = op; size = 2'(sz); rs2_raw = a; mem_raw = b;
    m_valid = v;
    if (v) begin
      m_tag = tag;
      uns = (op == 5'd24) || (op == 5'd28);
      legal = 1'b1;
      x = ref_ext(a, sz, !uns);
      y = ref_ext(b, sz, !uns);
      case (op)
        5'd1:  r = x;
        5'd0:  r = x + y;
        5'd4:  r = x ^ y;
        5'd12: r = x & y;
        5'd8:  r = x | y;
        5'd16: r = (longint'(x) < longint'(y)) ? x : y;
        5'd20: r = (longint'(x) > longint'(y)) ? x : y;
        5'd24: r = (x < y) ? x : y;
        5'd28: r = (x > y) ? x : y;
        default: begin r = 0; legal = 1'b0; end
      endcase
      m_ill = !legal;
      m_store = legal ? ref_ext(r, sz, 1'b0) : 64'd0;
      m_rd = legal ? ref_ext(b, sz, 1'b1) : 64'd0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid", 64'(out_valid), 0);
    check(illegal_op == 1'b0, "R1", "illegal_op", 64'(illegal_op), 0);
    check(store_data == 0, "R1", "store_data", store_data, 0);
    check(rd_value == 0, "R1", "rd_value", rd_value, 0);
    rst_n = 1'b1;
    step(1, 5'd1,  3, 64'h0123_4567_89AB_CDEF, 64'h5555_0000_1111_2222, "R3");
    step(1, 5'd0,  3, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R4");
    step(1, 5'd0,  0, 64'h7F, 64'h01, "R8");
    step(1, 5'd4,  2, 64'hAAAA_0000_F0F0_0F0F, 64'h0000_1111_FF00_00FF, "R5");
    step(1, 5'd12, 1, 64'h1234_5678_9ABC_F00F, 64'h0000_0000_0000_FF0F, "R5");
    step(1, 5'd8,  2, 64'h0000_0000_8000_0001, 64'h0000_0000_0000_0010, "R5");
    step(1, 5'd16, 0, 64'h80, 64'h01, "R2");
    step(1, 5'd24, 0, 64'h80, 64'h01, "R2");
    step(1, 5'd20, 2, 64'hFFFF_FFFF_FFFF_FFFE, 64'h8000_0000, "R6");
    step(1, 5'd28, 3, 64'h8000_0000_0000_0000, 64'd1, "R7");
    step(1, 5'd24, 0, 64'h05, 64'hF0, "R9");
    step(1, 5'd2,  2, 64'h1234, 64'h5678, "R10");
    step(0, 5'd0,  0, 64'hDEAD, 64'hBEEF, "R11");
    step(1, 5'd0,  1, 64'h0000_8000, 64'h0000_8000, "R4");
    step(0, 5'd1,  3, 64'h1, 64'h2, "R11");
    for (int i = 0; i < 400; i++) begin
      logic [4:0] op;
      op = ($urandom_range(0, 9) == 0) ? 5'($urandom) : 5'({$urandom_range(0, 7), 2'b00});
      if ($urandom_range(0, 7) == 0) op = 5'd1;
      step($urandom_range(0, 4) != 0, op, $urandom_range(0, 3),
           {$urandom, $urandom}, {$urandom, $urandom}, tag_of(op));
    end
    step(0, 5'd0, 0, 0, 0, "R11");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule